// File: doc/BRIEF.md
# Host/Processor Shared SRAM Handoff Controller

This block places one SRAM between two masters: a host port, which loads programs and collects results, and an embedded processor, which runs those programs. A single ownership flag chooses which master's address, write data, write strobe and read strobe reach the SRAM. Read data goes only to the current owner. The side that does not own the memory reads zero.

After reset the host owns the memory. The processor sits in a boot loop that polls one fixed address. The block watches the processor address bus for that address. When it sees the poll, it sends the host a one-cycle ready pulse. The host then writes a program and issues a start request, which passes ownership to the processor. The processor has been reading zeros, so it stays in its loop until it gets real data. When it finishes and fetches the poll address again, ownership returns to the host and the host gets another ready pulse. The host can then read the results.

Top module: `mem_handoff_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `proc_run` is 0 (host owns the memory) and `host_ready` is 0.
- R2: While `proc_run` is 0, `sram_addr`, `sram_wdata`, `sram_we` and `sram_oe` equal `host_addr`, `host_wdata`, `host_we` and `host_re` in the same cycle.
- R3: While `proc_run` is 0, `cpu_rdata` reads as all zeros, whatever the SRAM returns.
- R4: A `host_start` of 1 sampled on a clock edge while `proc_run` is 0 makes `proc_run` equal 1 after that edge.
- R5: While `proc_run` is 1, `sram_addr`, `sram_wdata`, `sram_we` and `sram_oe` equal `cpu_addr`, `cpu_wdata`, `cpu_we` and `cpu_oe`; `cpu_rdata` equals `sram_rdata`; `host_rdata` reads as zero.
- R6: A `cpu_addr` equal to the parameter `POLL_ADDR`, sampled on an edge while `proc_run` is 1, makes `proc_run` 0 and `host_ready` 1 after that edge. `host_ready` is 0 again one cycle later.
- R7: A `host_start` sampled while `proc_run` is 1 has no effect: `proc_run` stays 1 and the SRAM stays on the processor side.
- R8: Polls while the host owns the memory produce exactly one `host_ready` pulse, one cycle after the first poll edge. Further polls produce none until a start has been accepted. `host_ready` is only ever 1 in the cycle after a poll edge.
- R9: While `proc_run` is 0, `host_rdata` equals `sram_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host SRAM address |
| host_wdata | input | DATA_W | Host write data |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_start | input | 1 | Host request to hand memory to the processor |
| host_rdata | output | DATA_W | Read data toward host (zero when not owner) |
| host_ready | output | 1 | One-cycle ready notification |
| proc_run | output | 1 | 1 while the processor owns the SRAM |
| cpu_addr | input | ADDR_W | Processor address bus |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_we | input | 1 | Processor write strobe |
| cpu_oe | input | 1 | Processor output enable |
| cpu_rdata | output | DATA_W | Read data toward processor (zero when not owner) |
| sram_addr | output | ADDR_W | SRAM address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_we | output | 1 | SRAM write strobe |
| sram_oe | output | 1 | SRAM output enable |
| sram_rdata | input | DATA_W | SRAM read data |

## Verification
If the ownership flag is wrong, the fault shows in the same cycle: every SRAM-side output follows the wrong master, and the wrong side sees read data. A wrong start or poll transition shows on `proc_run` one edge after the stimulus. A wrong notification-arming state shows one edge after a poll, as a missing or extra `host_ready` pulse. The bench backs the SRAM with a small memory and sweeps every address from both sides. It also checks each of these transitions at the first cycle where the error would appear.

// File: rtl/handoff_pkg.sv
package handoff_pkg;

    localparam int DEF_ADDR_W = 8;
    localparam int DEF_DATA_W = 16;

    typedef enum logic {
        OWNER_HOST = 1'b0,
        OWNER_CPU  = 1'b1
    } owner_e;

    // Sequencer state carried between cycles
    typedef struct packed {
        owner_e owner;
        logic   armed;   // next poll seen by the host side raises a notification
        logic   ready;   // registered notification pulse
    } seq_state_t;

    localparam seq_state_t SEQ_RESET = '{owner: OWNER_HOST, armed: 1'b1, ready: 1'b0};

    function automatic logic cpu_owns(input owner_e o);
        return o == OWNER_CPU;
    endfunction

endpackage

// File: rtl/handoff_poll_det.sv
module handoff_poll_det #(
    parameter int                ADDR_W    = handoff_pkg::DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] POLL_ADDR = '1
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              hit
);
    always_comb hit = (cpu_addr == POLL_ADDR);
endmodule

// File: rtl/handoff_seq.sv
module handoff_seq
    import handoff_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_req,
    input  logic   poll_hit,
    output owner_e owner,
    output logic   ready
);
    seq_state_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b0;
        if (!cpu_owns(st_q.owner)) begin
            if (poll_hit && st_q.armed) begin
                st_d.ready = 1'b1;
                st_d.armed = 1'b0;
            end
            if (start_req) begin
                st_d.owner = OWNER_CPU;
                st_d.armed = 1'b1;
            end
        end else if (poll_hit) begin
            st_d.owner = OWNER_HOST;
            st_d.ready = 1'b1;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SEQ_RESET;
        else     st_q <= st_d;
    end

    assign owner = st_q.owner;
    assign ready = st_q.ready;
endmodule

// File: rtl/handoff_path.sv
module handoff_path
    import handoff_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  owner_e            owner,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_we,
    input  logic              host_re,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    input  logic              cpu_oe,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    output logic              sram_we,
    output logic              sram_oe,
    input  logic [DATA_W-1:0] sram_rdata
);
    localparam logic [DATA_W-1:0] ZERO_WORD = '0;

    logic sel_cpu;
    assign sel_cpu = cpu_owns(owner);

    always_comb begin
        if (sel_cpu) begin
            sram_addr  = cpu_addr;
            sram_wdata = cpu_wdata;
            sram_we    = cpu_we;
            sram_oe    = cpu_oe;
            cpu_rdata  = sram_rdata;
            host_rdata = ZERO_WORD;
        end else begin
            sram_addr  = host_addr;
            sram_wdata = host_wdata;
            sram_we    = host_we;
            sram_oe    = host_re;
            cpu_rdata  = ZERO_WORD;  // keeps the boot loop polling
            host_rdata = sram_rdata;
        end
    end
endmodule

// File: rtl/mem_handoff_ctrl.sv
module mem_handoff_ctrl
    import handoff_pkg::*;
#(
    parameter int                ADDR_W    = DEF_ADDR_W,
    parameter int                DATA_W    = DEF_DATA_W,
    parameter logic [ADDR_W-1:0] POLL_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_we,
    input  logic              host_re,
    input  logic              host_start,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ready,
    output logic              proc_run,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    input  logic              cpu_oe,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    output logic              sram_we,
    output logic              sram_oe,
    input  logic [DATA_W-1:0] sram_rdata
);
    logic   poll_hit;
    owner_e owner;

    handoff_poll_det #(.ADDR_W(ADDR_W), .POLL_ADDR(POLL_ADDR)) u_det (
        .cpu_addr (cpu_addr),
        .hit      (poll_hit)
    );

    handoff_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (host_start),
        .poll_hit  (poll_hit),
        .owner     (owner),
        .ready     (host_ready)
    );

    handoff_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
        .owner      (owner),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_we    (host_we),
        .host_re    (host_re),
        .host_rdata (host_rdata),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_we     (cpu_we),
        .cpu_oe     (cpu_oe),
        .cpu_rdata  (cpu_rdata),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .sram_we    (sram_we),
        .sram_oe    (sram_oe),
        .sram_rdata (sram_rdata)
    );

    assign proc_run = cpu_owns(owner);
endmodule

// File: rtl/handoff_chk.sv
module handoff_chk #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 16,
    parameter logic [ADDR_W-1:0] POLL_ADDR = '1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic              host_we,
    input logic              host_re,
    input logic              host_start,
    input logic [DATA_W-1:0] host_rdata,
    input logic              host_ready,
    input logic              proc_run,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_we,
    input logic              cpu_oe,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_wdata,
    input logic              sram_we,
    input logic              sram_oe,
    input logic [DATA_W-1:0] sram_rdata
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!proc_run && !host_ready));

    assert_host_path_R2: assert property (@(posedge clk) disable iff (rst)
        !proc_run |-> (sram_addr == host_addr && sram_wdata == host_wdata
                       && sram_we == host_we && sram_oe == host_re));

    assert_cpu_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !proc_run |-> (cpu_rdata == '0));

    assert_start_take_R4: assert property (@(posedge clk) disable iff (rst)
        (!proc_run && host_start) |=> proc_run);

    assert_cpu_path_R5: assert property (@(posedge clk) disable iff (rst)
        proc_run |-> (sram_addr == cpu_addr && sram_wdata == cpu_wdata
                      && sram_we == cpu_we && sram_oe == cpu_oe
                      && cpu_rdata == sram_rdata && host_rdata == '0));

    assert_poll_return_R6: assert property (@(posedge clk) disable iff (rst)
        (proc_run && cpu_addr == POLL_ADDR) |=> (!proc_run && host_ready));

    assert_ready_single_R6: assert property (@(posedge clk) disable iff (rst)
        host_ready |=> !host_ready);

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (proc_run && host_start && cpu_addr != POLL_ADDR) |=> proc_run);

    assert_ready_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(host_ready) |-> ($past(cpu_addr) == POLL_ADDR));

    assert_host_read_R9: assert property (@(posedge clk) disable iff (rst)
        !proc_run |-> (host_rdata == sram_rdata));
endmodule

bind mem_handoff_ctrl handoff_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .POLL_ADDR (POLL_ADDR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_start (host_start),
    .host_rdata (host_rdata),
    .host_ready (host_ready),
    .proc_run   (proc_run),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_we     (cpu_we),
    .cpu_oe     (cpu_oe),
    .cpu_rdata  (cpu_rdata),
    .sram_addr  (sram_addr),
    .sram_wdata (sram_wdata),
    .sram_we    (sram_we),
    .sram_oe    (sram_oe),
    .sram_rdata (sram_rdata)
);

// File: tb/tb_mem_handoff_ctrl.sv
module tb_mem_handoff_ctrl;
    localparam int            AW    = 4;
    localparam int            DW    = 8;
    localparam int            DEPTH = 1 << AW;
    localparam logic [AW-1:0] POLL  = 4'hC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_we = 1'b0, host_re = 1'b0, host_start = 1'b0;
    logic [DW-1:0] host_rdata;
    logic          host_ready, proc_run;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_we = 1'b0, cpu_oe = 1'b0;
    logic [DW-1:0] cpu_rdata;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_wdata;
    logic          sram_we, sram_oe;
    logic [DW-1:0] sram_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    mem_handoff_ctrl #(.ADDR_W(AW), .DATA_W(DW), .POLL_ADDR(POLL)) dut (
        .clk(clk), .rst(rst),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_we(host_we),
        .host_re(host_re), .host_start(host_start), .host_rdata(host_rdata),
        .host_ready(host_ready), .proc_run(proc_run),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
        .cpu_oe(cpu_oe), .cpu_rdata(cpu_rdata),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_we(sram_we),
        .sram_oe(sram_oe), .sram_rdata(sram_rdata)
    );

    // SRAM model
    logic [DW-1:0] mem [DEPTH];
    initial for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    always @(posedge clk) if (sram_we) mem[sram_addr] <= sram_wdata;
    assign sram_rdata = sram_oe ? mem[sram_addr] : '0;

    function automatic logic [DW-1:0] host_pat(input int a);
        return DW'(a * 7 + 1);
    endfunction
    function automatic logic [DW-1:0] cpu_pat(input int a);
        return DW'(a * 13 + 5);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=completion");
        summary();
        $finish;
    end

    int pulses;

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 proc_run in reset", proc_run, 0);
        chk("R1 host_ready in reset", host_ready, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 proc_run after reset", proc_run, 0);
        chk("R1 host_ready after reset", host_ready, 0);

        // Host writes program: sweep all addresses (R2, R3)
        cpu_addr = 4'h1;
        cpu_oe   = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            host_addr = AW'(a); host_wdata = host_pat(a); host_we = 1'b1;
            #1;
            chk("R2 sram_addr host", sram_addr, a);
            chk("R2 sram_wdata host", sram_wdata, host_pat(a));
            chk("R2 sram_we host", sram_we, 1);
            chk("R3 cpu_rdata zero", cpu_rdata, 0);
            @(negedge clk);
        end
        host_we = 1'b0;

        // Host reads back (R9, R2, R3)
        host_re = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            host_addr = AW'(a);
            #1;
            chk("R2 sram_oe host", sram_oe, 1);
            chk("R9 host_rdata", host_rdata, host_pat(a));
            chk("R3 cpu_rdata zero on read", cpu_rdata, 0);
            @(negedge clk);
        end
        host_re = 1'b0;
        chk("R8 no ready before poll", host_ready, 0);

        // First poll while idle: exactly one pulse (R8)
        cpu_addr = POLL;
        pulses = 0;
        @(negedge clk);
        chk("R8 ready one cycle after first poll", host_ready, 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            pulses += int'(host_ready);
        end
        chk("R8 no repeat pulse while polling", pulses, 0);
        chk("R8 still host-owned", proc_run, 0);

        // Start (R4)
        cpu_addr   = 4'h0;
        host_start = 1'b1;
        #1;
        chk("R4 not owned before edge", proc_run, 0);
        @(negedge clk);
        host_start = 1'b0;
        chk("R4 proc_run after start", proc_run, 1);
        chk("R4 no ready on start", host_ready, 0);

        // Processor reads program and writes results, with stray starts (R5, R7)
        for (int a = 0; a < DEPTH; a++) begin
            if (AW'(a) == POLL) continue;
            cpu_addr = AW'(a); cpu_oe = 1'b1; cpu_we = 1'b0;
            host_addr = AW'(DEPTH - 1 - a); host_re = 1'b1;
            host_start = a[0];
            #1;
            chk("R5 sram_addr cpu", sram_addr, a);
            chk("R5 sram_oe cpu", sram_oe, 1);
            chk("R5 cpu_rdata", cpu_rdata, host_pat(a));
            chk("R5 host_rdata zero", host_rdata, 0);
            @(negedge clk);
            chk("R7 start ignored", proc_run, 1);
            cpu_we = 1'b1; cpu_oe = 1'b0; cpu_wdata = cpu_pat(a); host_start = 1'b0;
            host_we = 1'b1; host_wdata = 8'hEE;
            #1;
            chk("R5 sram_we cpu", sram_we, 1);
            chk("R5 sram_wdata cpu", sram_wdata, cpu_pat(a));
            @(negedge clk);
            host_we = 1'b0;
        end
        cpu_we = 1'b0; cpu_oe = 1'b0; host_re = 1'b0;
        chk("R7 still processor-owned", proc_run, 1);

        // Completion poll (R6)
        cpu_addr = POLL;
        @(negedge clk);
        chk("R6 ownership returned", proc_run, 0);
        chk("R6 ready pulse", host_ready, 1);
        cpu_addr = 4'h3;
        @(negedge clk);
        chk("R6 ready one cycle only", host_ready, 0);

        // Host reads results (R9, R3)
        host_re = 1'b1;
        cpu_oe  = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            host_addr = AW'(a);
            #1;
            chk("R9 results", host_rdata, (AW'(a) == POLL) ? host_pat(a) : cpu_pat(a));
            chk("R3 cpu_rdata zero after return", cpu_rdata, 0);
            @(negedge clk);
        end
        host_re = 1'b0;

        // Further polls while host owns: no new pulse (R8)
        cpu_addr = POLL;
        pulses = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            pulses += int'(host_ready);
        end
        chk("R8 no pulse after return", pulses, 0);

        // Second run: start then immediate poll (R4, R6)
        cpu_addr   = 4'h2;
        host_start = 1'b1;
        @(negedge clk);
        host_start = 1'b0;
        chk("R4 second start", proc_run, 1);
        cpu_addr = POLL;
        @(negedge clk);
        chk("R6 second return", proc_run, 0);
        chk("R6 second ready", host_ready, 1);
        @(negedge clk);
        chk("R8 pulse ends while polling", host_ready, 0);

        summary();
        $finish;
    end
endmodule